// File: doc/BRIEF.md
# Outstanding Miss Request Tracker

This block sits between a requesting core and its cache controller and keeps track of every memory request that has been sent out and not yet answered. Requests are identified by the cache line they touch. Pure reads (loads and instruction fetches) are held in a read table. Anything that may modify the line is held in a separate write table: stores, both halves of a read-modify-write, and both halves of a locked pair. Each entry holds only the line tag, the request kind, a request identifier and the time the request was issued. Data, the cache array and the coherence protocol all live elsewhere.

The requester presents a request and gets an answer in the same cycle. The request is either accepted (it is allocated at the next clock edge and given the next identifier) or rejected. A rejection gives the reason: a bad size or kind, a line already pending, or no room. The controller signals completions by line and by table. The tracker frees the entry and reports, combinationally, the identifier, the kind and the latency in cycles. A completion with no matching entry is flagged. While anything is outstanding, a periodic watchdog scans the entry ages and raises a sticky deadlock flag when an entry has waited too long.

Top module: `miss_tracker`

## Requirements
- R1: Kinds are encoded on 3 bits: 0 load, 1 instruction fetch, 2 store, 3 read-modify-write read, 4 read-modify-write write, 5 locked read, 6 locked write, 7 reserved. Kinds 2 to 6 go to the write table and kinds 0 and 1 go to the read table. A completion is looked up only in the table selected by `cpl_is_write`.
- R2: A request whose line (the address above the offset bits) is pending in either table is given status 1 (alias) and is not allocated.
- R3: A request is given status 2 (full) when the outstanding count is at or above `MAX_OUT`, or when its target table has no free entry. Status 0 means accept. The priority is bad (3), then alias (1), then full (2), then accept (0). The status is computed combinationally whether or not `req_valid` is high.
- R4: The outstanding count always equals read-table occupancy plus write-table occupancy. An accept and a completion in the same cycle both take effect. The alias and full decisions in that cycle use the state from before the clock edge.
- R5: When a completion is driven N clock edges after the edge that accepted the entry, `cpl_lat` reads N. `cpl_lat_vld` is high when the completion matches and the latency is nonzero.
- R6: While the tracker is not empty, the watchdog scans every `THRESH` cycles, counting from the cycle the tracker was last empty. If any entry's age is at or above `THRESH` at a scan, `deadlock` rises and stays high until reset. An entry accepted into an empty tracker raises `deadlock` exactly `THRESH` edges after its accept edge.
- R7: A completion that matches an entry in its selected table gives `cpl_hit` and frees that entry. Otherwise it gives `cpl_err`, and no entry is freed.
- R8: A request whose offset within the line plus its length exceeds `LINE_BYTES`, or whose kind is 7, is given status 3 (bad) and is not allocated.
- R9: Identifiers start at 0 after reset and advance by one on each accepted request only. `req_id` shows the identifier the next accept will take. A completion returns the identifier and kind of the freed entry.
- R10: `empty` is high exactly when neither table holds a valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; it is allocated at the edge if the status is 0 |
| req_kind | input | 3 | Request kind (encoding in R1) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | LEN_W | Request length in bytes |
| req_status | output | 2 | 0 accept, 1 alias, 2 full, 3 bad |
| req_id | output | ID_W | Identifier the next accepted request receives |
| cpl_valid | input | 1 | Completion present |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_line | input | TAG_W | Line address of the completion |
| cpl_hit | output | 1 | Completion matched and frees an entry |
| cpl_err | output | 1 | Completion matched nothing |
| cpl_id | output | ID_W | Identifier of the matched entry |
| cpl_kind | output | 3 | Kind of the matched entry |
| cpl_lat | output | TIME_W | Cycles since the entry was accepted |
| cpl_lat_vld | output | 1 | Hit with nonzero latency |
| empty | output | 1 | No entry outstanding |
| deadlock | output | 1 | Sticky watchdog flag |

## Verification
The cycle that matters most is one where a completion frees an entry and a new request is decided at the same moment. The bench fills the tracker to its limit. It then completes one line while requesting a different line, and expects a full rejection together with a completion hit. In a second step it completes a line while requesting that same line, and expects an alias rejection together with a hit. In the cycle after each, the bench checks that the freed room and the freed line are actually usable again.

// File: rtl/mt_pkg.sv
package mt_pkg;

   localparam logic [2:0] K_LOAD    = 3'd0;
   localparam logic [2:0] K_IFETCH  = 3'd1;
   localparam logic [2:0] K_STORE   = 3'd2;
   localparam logic [2:0] K_RMW_RD  = 3'd3;
   localparam logic [2:0] K_RMW_WR  = 3'd4;
   localparam logic [2:0] K_LOCK_RD = 3'd5;
   localparam logic [2:0] K_LOCK_WR = 3'd6;
   localparam logic [2:0] K_RSVD    = 3'd7;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_ALIAS = 2'd1,
      ST_FULL  = 2'd2,
      ST_BAD   = 2'd3
   } status_e;

   function automatic logic kind_is_write(input logic [2:0] k);
      return (k == K_STORE) || (k == K_RMW_RD) || (k == K_RMW_WR) ||
             (k == K_LOCK_RD) || (k == K_LOCK_WR);
   endfunction

endpackage

// File: rtl/mt_table.sv
module mt_table #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 26,
   parameter int ID_W   = 8,
   parameter int TIME_W = 16,
   parameter int THRESH = 1024,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [2:0]        alloc_kind,
   input  logic [ID_W-1:0]   alloc_id,
   input  logic [TAG_W-1:0]  probe_tag,
   output logic              probe_hit,
   input  logic              ret_en,
   input  logic [TAG_W-1:0]  ret_tag,
   output logic              ret_hit,
   output logic [ID_W-1:0]   ret_id,
   output logic [2:0]        ret_kind,
   output logic [TIME_W-1:0] ret_ts,
   output logic              has_free,
   output logic [CNT_W-1:0]  occupancy,
   output logic              stale
);

   localparam logic [TIME_W-1:0] THRESH_T = TIME_W'(THRESH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("mt_table: DEPTH must be at least 1");
   end
   if (THRESH >= (2 ** TIME_W)) begin : g_bad_thresh
      $error("mt_table: THRESH must fit in TIME_W bits");
   end

   logic [DEPTH-1:0]  vld;
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [ID_W-1:0]   id_q   [DEPTH];
   logic [2:0]        kind_q [DEPTH];
   logic [TIME_W-1:0] ts_q   [DEPTH];
   logic [TIME_W-1:0] age    [DEPTH];
   logic [DEPTH-1:0]  probe_m, ret_m, old_m, free_m;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign probe_m[i] = vld[i] && (tag_q[i] == probe_tag);
      assign ret_m[i]   = vld[i] && (tag_q[i] == ret_tag);
      assign age[i]     = now - ts_q[i];
      assign old_m[i]   = vld[i] && (age[i] >= THRESH_T);
   end

   assign probe_hit = |probe_m;
   assign ret_hit   = |ret_m;
   assign stale     = |old_m;
   assign has_free  = ~&vld;

   // lowest free slot, one-hot
   always_comb begin
      logic found;
      found  = 1'b0;
      free_m = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld[i] && !found) begin
            free_m[i] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   // tags are unique within a table, so an OR of masked fields selects one
   always_comb begin
      ret_id   = '0;
      ret_kind = '0;
      ret_ts   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ret_m[i]) begin
            ret_id   = ret_id   | id_q[i];
            ret_kind = ret_kind | kind_q[i];
            ret_ts   = ret_ts   | ts_q[i];
         end
      end
   end

   always_comb begin
      occupancy = '0;
      for (int i = 0; i < DEPTH; i++) begin
         occupancy = occupancy + CNT_W'(vld[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_en && free_m[i]) begin
               vld[i] <= 1'b1;
            end else if (ret_en && ret_m[i]) begin
               vld[i] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc_en && free_m[i]) begin
            tag_q[i]  <= alloc_tag;
            id_q[i]   <= alloc_id;
            kind_q[i] <= alloc_kind;
            ts_q[i]   <= now;
         end
      end
   end

endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog #(
   parameter int THRESH = 1024,
   localparam int CW = (THRESH > 2) ? $clog2(THRESH) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic empty,
   input  logic stale,
   output logic deadlock
);

   if (THRESH < 2) begin : g_bad_thresh
      $error("mt_watchdog: THRESH must be at least 2");
   end

   logic [CW-1:0] tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q   <= '0;
         deadlock <= 1'b0;
      end else if (empty) begin
         tick_q <= '0;
      end else if (tick_q == CW'(THRESH - 1)) begin
         tick_q <= '0;
         if (stale) begin
            deadlock <= 1'b1;
         end
      end else begin
         tick_q <= tick_q + CW'(1);
      end
   end

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int RD_DEPTH   = 8,
   parameter int WR_DEPTH   = 8,
   parameter int MAX_OUT    = 12,
   parameter int ID_W       = 8,
   parameter int TIME_W     = 16,
   parameter int THRESH     = 1024,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int TAG_W     = ADDR_W - OFF_W,
   localparam int LEN_W     = $clog2(LINE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic [1:0]        req_status,
   output logic [ID_W-1:0]   req_id,
   input  logic              cpl_valid,
   input  logic              cpl_is_write,
   input  logic [TAG_W-1:0]  cpl_line,
   output logic              cpl_hit,
   output logic              cpl_err,
   output logic [ID_W-1:0]   cpl_id,
   output logic [2:0]        cpl_kind,
   output logic [TIME_W-1:0] cpl_lat,
   output logic              cpl_lat_vld,
   output logic              empty,
   output logic              deadlock
);
   import mt_pkg::*;

   localparam int OUT_W = $clog2(RD_DEPTH + WR_DEPTH + 1);
   localparam int RCW   = $clog2(RD_DEPTH + 1);
   localparam int WCW   = $clog2(WR_DEPTH + 1);

   if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("miss_tracker: LINE_BYTES must be a power of two above 1");
   end
   if (MAX_OUT < 1 || MAX_OUT > RD_DEPTH + WR_DEPTH) begin : g_bad_max
      $error("miss_tracker: MAX_OUT must lie in 1..RD_DEPTH+WR_DEPTH");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("miss_tracker: ADDR_W too small for LINE_BYTES");
   end

   logic [TIME_W-1:0] now;
   logic [ID_W-1:0]   next_id;
   logic [OUT_W-1:0]  out_cnt;

   logic [TAG_W-1:0]  req_line;
   logic [OFF_W-1:0]  req_off;
   logic [LEN_W:0]    span;
   logic              size_bad, want_wr, alias_hit, no_room, accept;
   status_e           status;

   logic              rd_probe, wr_probe, rd_free, wr_free, rd_stale, wr_stale;
   logic              rd_ret, wr_ret;
   logic [ID_W-1:0]   rd_id, wr_id;
   logic [2:0]        rd_kind, wr_kind;
   logic [TIME_W-1:0] rd_ts, wr_ts, sel_ts;
   logic [RCW-1:0]    rd_occ;
   logic [WCW-1:0]    wr_occ;

   assign req_line = req_addr[ADDR_W-1:OFF_W];
   assign req_off  = req_addr[OFF_W-1:0];
   assign span     = (LEN_W + 1)'(req_off) + (LEN_W + 1)'(req_len);
   assign size_bad = (span > (LEN_W + 1)'(LINE_BYTES)) || (req_kind == K_RSVD);
   assign want_wr  = kind_is_write(req_kind);
   assign alias_hit = rd_probe || wr_probe;
   assign no_room  = (out_cnt >= OUT_W'(MAX_OUT)) || (want_wr ? !wr_free : !rd_free);

   always_comb begin
      if (size_bad)       status = ST_BAD;
      else if (alias_hit) status = ST_ALIAS;
      else if (no_room)   status = ST_FULL;
      else                status = ST_OK;
   end

   assign req_status = status;
   assign req_id     = next_id;
   assign accept     = req_valid && (status == ST_OK);

   mt_table #(
      .DEPTH(RD_DEPTH), .TAG_W(TAG_W), .ID_W(ID_W), .TIME_W(TIME_W), .THRESH(THRESH)
   ) u_rd_tbl (
      .clk(clk), .rst_n(rst_n), .now(now),
      .alloc_en(accept && !want_wr), .alloc_tag(req_line), .alloc_kind(req_kind),
      .alloc_id(next_id), .probe_tag(req_line), .probe_hit(rd_probe),
      .ret_en(cpl_valid && !cpl_is_write), .ret_tag(cpl_line), .ret_hit(rd_ret),
      .ret_id(rd_id), .ret_kind(rd_kind), .ret_ts(rd_ts),
      .has_free(rd_free), .occupancy(rd_occ), .stale(rd_stale)
   );

   mt_table #(
      .DEPTH(WR_DEPTH), .TAG_W(TAG_W), .ID_W(ID_W), .TIME_W(TIME_W), .THRESH(THRESH)
   ) u_wr_tbl (
      .clk(clk), .rst_n(rst_n), .now(now),
      .alloc_en(accept && want_wr), .alloc_tag(req_line), .alloc_kind(req_kind),
      .alloc_id(next_id), .probe_tag(req_line), .probe_hit(wr_probe),
      .ret_en(cpl_valid && cpl_is_write), .ret_tag(cpl_line), .ret_hit(wr_ret),
      .ret_id(wr_id), .ret_kind(wr_kind), .ret_ts(wr_ts),
      .has_free(wr_free), .occupancy(wr_occ), .stale(wr_stale)
   );

   assign cpl_hit     = cpl_valid && (cpl_is_write ? wr_ret : rd_ret);
   assign cpl_err     = cpl_valid && !cpl_hit;
   assign cpl_id      = cpl_is_write ? wr_id : rd_id;
   assign cpl_kind    = cpl_is_write ? wr_kind : rd_kind;
   assign sel_ts      = cpl_is_write ? wr_ts : rd_ts;
   assign cpl_lat     = now - sel_ts;
   assign cpl_lat_vld = cpl_hit && (cpl_lat != '0);

   assign empty = (rd_occ == '0) && (wr_occ == '0);

   mt_watchdog #(.THRESH(THRESH)) u_wdog (
      .clk(clk), .rst_n(rst_n), .empty(empty),
      .stale(rd_stale || wr_stale), .deadlock(deadlock)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now     <= '0;
         next_id <= '0;
         out_cnt <= '0;
      end else begin
         now     <= now + TIME_W'(1);
         next_id <= next_id + ID_W'(accept);
         out_cnt <= out_cnt + OUT_W'(accept) - OUT_W'(cpl_hit);
      end
   end

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
   parameter int ID_W    = 8,
   parameter int OUT_W   = 5,
   parameter int RCW     = 4,
   parameter int WCW     = 4,
   parameter int MAX_OUT = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [1:0]      req_status,
   input logic [ID_W-1:0] req_id,
   input logic            cpl_valid,
   input logic            cpl_hit,
   input logic            cpl_err,
   input logic            empty,
   input logic            deadlock,
   input logic [OUT_W-1:0] out_cnt,
   input logic [RCW-1:0]  rd_occ,
   input logic [WCW-1:0]  wr_occ
);

   AST_CNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      32'(out_cnt) == 32'(rd_occ) + 32'(wr_occ)); // R4

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      32'(out_cnt) <= MAX_OUT); // R3

   AST_ALIAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_status == 2'd1) |-> !empty); // R2

   AST_FULL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_status == 2'd2) |-> !empty); // R3

   AST_ACCEPT_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_status == 2'd0) |=> !empty); // R10

   AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_status == 2'd0) |=> (req_id == $past(req_id) + ID_W'(1))); // R9

   AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_status == 2'd0) |=> $stable(req_id)); // R9

   AST_CPL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> (cpl_hit != cpl_err)); // R7

   AST_DEADLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> deadlock); // R6

endmodule

bind miss_tracker mt_checker #(
   .ID_W(ID_W), .OUT_W(OUT_W), .RCW(RCW), .WCW(WCW), .MAX_OUT(MAX_OUT)
) u_mt_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_status(req_status),
   .req_id(req_id), .cpl_valid(cpl_valid), .cpl_hit(cpl_hit), .cpl_err(cpl_err),
   .empty(empty), .deadlock(deadlock), .out_cnt(out_cnt),
   .rd_occ(rd_occ), .wr_occ(wr_occ)
);

// File: tb/tb_miss_tracker.sv
`timescale 1ns/1ps
module tb_miss_tracker;

   localparam int ADDR_W = 12;
   localparam int LB     = 16;
   localparam int RD     = 2;
   localparam int WR     = 2;
   localparam int MAXO   = 3;
   localparam int IDW    = 8;
   localparam int TW     = 12;
   localparam int TH     = 32;
   localparam int TAGW   = ADDR_W - 4;
   localparam int LENW   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [2:0] req_kind = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [LENW-1:0] req_len = '0;
   logic [1:0] req_status;
   logic [IDW-1:0] req_id;
   logic cpl_valid = 1'b0;
   logic cpl_is_write = 1'b0;
   logic [TAGW-1:0] cpl_line = '0;
   logic cpl_hit, cpl_err, cpl_lat_vld, empty, deadlock;
   logic [IDW-1:0] cpl_id;
   logic [2:0] cpl_kind;
   logic [TW-1:0] cpl_lat;

   int nchk = 0;
   int nbad = 0;
   int exp_id = 0;

   always #4 clk = ~clk;

   miss_tracker #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LB), .RD_DEPTH(RD), .WR_DEPTH(WR),
      .MAX_OUT(MAXO), .ID_W(IDW), .TIME_W(TW), .THRESH(TH)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_len(req_len), .req_status(req_status),
      .req_id(req_id), .cpl_valid(cpl_valid), .cpl_is_write(cpl_is_write),
      .cpl_line(cpl_line), .cpl_hit(cpl_hit), .cpl_err(cpl_err),
      .cpl_id(cpl_id), .cpl_kind(cpl_kind), .cpl_lat(cpl_lat),
      .cpl_lat_vld(cpl_lat_vld), .empty(empty), .deadlock(deadlock)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      req_valid = 1'b0;
      cpl_valid = 1'b0;
   endtask

   task automatic drive_req(input logic v, input logic [2:0] k, input int line,
                            input int off, input int len);
      req_valid = v;
      req_kind  = k;
      req_addr  = ADDR_W'((line << 4) | off);
      req_len   = LENW'(len);
   endtask

   task automatic drive_cpl(input logic wr, input int line);
      cpl_valid    = 1'b1;
      cpl_is_write = wr;
      cpl_line     = TAGW'(line);
   endtask

   // accept and commit at the next edge
   task automatic accept(input logic [2:0] k, input int line, input string tag);
      drive_req(1'b1, k, line, 0, 4);
      #1;
      chk({tag, " accept status"}, int'(req_status), 0);
      chk({tag, " accept id"}, int'(req_id), exp_id);
      tick();
      exp_id++;
      idle();
   endtask

   task automatic retire(input logic wr, input int line, input string tag);
      drive_cpl(wr, line);
      #1;
      chk({tag, " cpl_hit"}, int'(cpl_hit), 1);
      tick();
      idle();
   endtask

   initial begin
      #(200000 * 8);
      nbad++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", nchk, 0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk("R10 reset empty", int'(empty), 1);
      chk("R6 reset deadlock", int'(deadlock), 0);
      chk("R9 reset id", int'(req_id), 0);

      // R8 exhaustive size sweep, status computed without req_valid
      for (int off = 0; off < LB; off++) begin
         for (int len = 0; len <= LB; len++) begin
            drive_req(1'b0, 3'd0, 5, off, len);
            #1;
            chk($sformatf("R8 size off=%0d len=%0d", off, len), int'(req_status),
                (off + len > LB) ? 3 : 0);
         end
      end
      drive_req(1'b0, 3'd7, 5, 0, 4);
      #1 chk("R8 reserved kind", int'(req_status), 3);
      drive_req(1'b1, 3'd0, 5, 12, 8);
      tick();
      idle();
      #1;
      chk("R8 bad request not allocated", int'(empty), 1);
      chk("R9 bad request keeps id", int'(req_id), exp_id);

      // R1 R7 R9 R5: each kind routed to its table
      for (int k = 0; k < 7; k++) begin
         automatic logic wr = (k >= 2);
         accept(3'(k), 16 + k, "R1");
         drive_cpl(!wr, 16 + k);
         #1;
         chk($sformatf("R1 kind %0d wrong table err", k), int'(cpl_err), 1);
         chk($sformatf("R7 kind %0d wrong table no hit", k), int'(cpl_hit), 0);
         drive_cpl(wr, 16 + k);
         #1;
         chk($sformatf("R1 kind %0d right table hit", k), int'(cpl_hit), 1);
         chk($sformatf("R9 kind %0d cpl id", k), int'(cpl_id), exp_id - 1);
         chk($sformatf("R9 kind %0d cpl kind", k), int'(cpl_kind), k);
         chk($sformatf("R5 kind %0d lat", k), int'(cpl_lat), 1);
         chk($sformatf("R5 kind %0d lat_vld", k), int'(cpl_lat_vld), 1);
         tick();
         idle();
         #1 chk($sformatf("R10 kind %0d empty after", k), int'(empty), 1);
      end
      drive_cpl(1'b0, 99);
      #1 chk("R7 unmatched completion err", int'(cpl_err), 1);
      tick();
      idle();

      // R2 alias
      accept(3'd0, 40, "R2");
      drive_req(1'b1, 3'd2, 40, 8, 4);
      #1 chk("R2 store to pending read line", int'(req_status), 1);
      tick();
      idle();
      #1 chk("R2 alias not allocated id", int'(req_id), exp_id);
      drive_req(1'b0, 3'd1, 40, 0, 4);
      #1 chk("R2 fetch to pending line", int'(req_status), 1);
      accept(3'd0, 41, "R2");
      retire(1'b0, 40, "R2");
      retire(1'b0, 41, "R2");
      #1 chk("R10 empty after alias test", int'(empty), 1);

      // R3 full and R4 same-cycle
      accept(3'd0, 50, "R3");
      accept(3'd0, 51, "R3");
      drive_req(1'b0, 3'd0, 52, 0, 4);
      #1 chk("R3 read table full", int'(req_status), 2);
      accept(3'd2, 60, "R3");
      drive_req(1'b0, 3'd2, 61, 0, 4);
      #1 chk("R3 total at MAX_OUT", int'(req_status), 2);
      drive_req(1'b1, 3'd0, 52, 0, 4);
      drive_cpl(1'b0, 50);
      #1;
      chk("R4 same cycle full uses old count", int'(req_status), 2);
      chk("R4 same cycle completion hit", int'(cpl_hit), 1);
      tick();
      idle();
      accept(3'd0, 52, "R4 room after completion");
      drive_req(1'b1, 3'd2, 51, 0, 4);
      drive_cpl(1'b0, 51);
      #1;
      chk("R4 same cycle alias uses old table", int'(req_status), 1);
      chk("R4 same cycle alias completion hit", int'(cpl_hit), 1);
      tick();
      idle();
      drive_req(1'b0, 3'd2, 51, 0, 4);
      #1 chk("R4 freed line usable", int'(req_status), 0);
      chk("R9 id after same-cycle rejects", int'(req_id), exp_id);
      retire(1'b0, 52, "R4");
      retire(1'b1, 60, "R4");
      #1 chk("R10 empty after drain", int'(empty), 1);

      // R5 latency
      accept(3'd3, 70, "R5");
      repeat (6) tick();
      drive_cpl(1'b1, 70);
      #1;
      chk("R5 latency 7", int'(cpl_lat), 7);
      chk("R5 lat_vld", int'(cpl_lat_vld), 1);
      chk("R9 cpl id latency", int'(cpl_id), exp_id - 1);
      tick();
      idle();
      tick();

      // R6 no fire below threshold
      accept(3'd0, 80, "R6");
      repeat (TH - 3) tick();
      retire(1'b0, 80, "R6");
      repeat (2 * TH) tick();
      chk("R6 young entry no deadlock", int'(deadlock), 0);

      // R6 fire exactly THRESH edges after accept
      accept(3'd0, 81, "R6");
      repeat (TH - 1) tick();
      chk("R6 deadlock before threshold", int'(deadlock), 0);
      tick();
      chk("R6 deadlock at threshold", int'(deadlock), 1);
      retire(1'b0, 81, "R6");
      repeat (3) tick();
      chk("R6 deadlock sticky", int'(deadlock), 1);
      chk("R10 empty at end", int'(empty), 1);

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule